// File: doc/BRIEF.md
# UART Receive Break Detector

This block sits beside a UART receiver core and watches two things: the result of every completed frame (data bits, parity bit, stop bit) and the oversampled receive line together with its sample strobe. A frame whose data, parity and stop bits all read zero is treated as a line break. It is reported on a dedicated sticky break flag and not as a framing error. Any other frame with a zero stop bit sets a sticky framing-error flag.

Once a break has been seen, the block arms an end-of-break detector. In asynchronous mode, the end of the break is taken when the line reads high on a parameterised number of consecutive samples. The default is 2 samples, which is 2/16 of a bit at 16x oversampling. In synchronous mode, the first high sample ends the break. The end of a break sets the same break flag again, and the detector then returns to idle.

Software-facing logic clears both flags with a status-reset strobe. An interrupt request follows the break flag, gated by a mask bit.

Top module: `uart_break_detector`

## Requirements
- R1: A frame strobe whose data bits, parity bit and stop bit are all 0 sets `brk_flag` on the next clock edge and leaves `frame_err` at 0.
- R2: A frame strobe with stop bit 0 and a non-zero data field or parity bit 1 sets `frame_err` and leaves `brk_flag` unchanged.
- R3: A frame strobe with stop bit 1 sets neither flag.
- R4: `irq` is 1 exactly while `brk_flag` is 1 and `brk_mask` is 1, with no clock delay.
- R5: A `status_clr` pulse with no concurrent set event clears `brk_flag` and `frame_err` on the next edge.
- R6: When a flag-set event and `status_clr` occur in the same cycle, the flag ends up set.
- R7: With `sync_mode` = 0 and a break active, `brk_flag` is set when `line_in` reads 1 on HIGH_SAMPLES (default 2) consecutive sample ticks. A low sample restarts the count.
- R8: With `sync_mode` = 1 and a break active, the first sample tick that reads `line_in` = 1 sets `brk_flag`.
- R9: End-of-break detection is active only after a break frame. After an end of break the block is idle, and further high samples set nothing.
- R10: `line_in` is only looked at in cycles where `sample_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: a frame has completed |
| frame_data | input | DATA_W | Received data bits |
| frame_parity | input | 1 | Received parity bit |
| frame_stop | input | 1 | Received stop bit |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| line_in | input | 1 | Oversampled receive line value |
| sample_tick | input | 1 | Qualifies `line_in` as a new sample |
| brk_mask | input | 1 | Enables the interrupt from `brk_flag` |
| status_clr | input | 1 | Clears both status flags |
| brk_flag | output | 1 | Sticky break / end-of-break flag |
| frame_err | output | 1 | Sticky framing-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench separates break frames from frames that differ from a break in only one bit: a set LSB, a set MSB, a set parity bit, or a set stop bit. A classifier that ignored parity or part of the data would report a break where a framing error belongs. In asynchronous mode the bench interrupts a run of high samples with a low one, and it toggles the line on cycles without a sample tick. A counter that does not restart, or that samples every cycle, would end the break early. The bench also raises a set event and a clear in the same cycle. It sends high samples while idle and again after a break has ended, where a detector that stays armed would raise the flag a second time.

// File: rtl/brk_pkg.sv
package brk_pkg;
    // Break tracking state of the end-of-break detector
    typedef enum logic {
        BRK_IDLE   = 1'b0,
        BRK_ACTIVE = 1'b1
    } brk_state_t;
endpackage

// File: rtl/brk_frame_classify.sv
// Classifies each completed frame as a break, a framing error or normal.
// Assumes frame fields are valid only while frame_valid is high.
module brk_frame_classify #(
    parameter int DATA_W = 8
) (
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_parity,
    input  logic              frame_stop,
    output logic              is_break,
    output logic              is_ferr
);
    logic all_zero;

    // Decide frame class from the received bits
    always_comb begin
        all_zero = ~(|frame_data) & ~frame_parity & ~frame_stop;
        is_break = frame_valid & all_zero;
        is_ferr  = frame_valid & ~frame_stop & ~all_zero;
    end
endmodule

// File: rtl/brk_end_detect.sv
// Tracks whether a break is in progress and flags its end from line samples.
// Assumes sample_tick marks each oversampled line value; HIGH_SAMPLES >= 1.
module brk_end_detect
    import brk_pkg::*;
#(
    parameter int HIGH_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic break_seen,
    input  logic sync_mode,
    input  logic line_in,
    input  logic sample_tick,
    output logic end_evt,
    output logic in_break
);
    localparam int CNT_W = $clog2(HIGH_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HIGH_SAMPLES - 1);

    brk_state_t       state;
    logic [CNT_W-1:0] hi_cnt;

    // End of break: enough consecutive high samples (async) or any high one (sync)
    always_comb begin
        in_break = (state == BRK_ACTIVE);
        end_evt  = in_break & sample_tick & line_in & (sync_mode | (hi_cnt == LAST));
    end

    // Break state and consecutive-high sample counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BRK_IDLE;
            hi_cnt <= '0;
        end else if (break_seen) begin
            state  <= BRK_ACTIVE;
            hi_cnt <= '0;
        end else if (in_break && sample_tick) begin
            if (end_evt) begin
                state  <= BRK_IDLE;
                hi_cnt <= '0;
            end else if (line_in) begin
                hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    // R7: the counter never passes the qualifying length
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt < CNT_W'(HIGH_SAMPLES));
    // R8: in synchronous mode a high sample during a break ends it
    assert_sync_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && sync_mode && sample_tick && line_in) |-> end_evt);
    // R9: after an end of break (with no new break) the detector is idle
    assert_end_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && !break_seen) |=> !in_break);
    // R10: without a sample tick the counter holds
    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !break_seen) |=> $stable(hi_cnt));
endmodule

// File: rtl/brk_status.sv
// Sticky break and framing-error flags with set-over-clear priority.
// Assumes set inputs are single-cycle events.
module brk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_set,
    input  logic ferr_set,
    input  logic status_clr,
    output logic brk_flag,
    output logic frame_err
);
    // Update sticky flags; a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_flag  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (brk_set)         brk_flag  <= 1'b1;
            else if (status_clr) brk_flag  <= 1'b0;
            if (ferr_set)        frame_err <= 1'b1;
            else if (status_clr) frame_err <= 1'b0;
        end
    end

    // R5: a clear without a set empties the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !brk_set) |=> !brk_flag);
    // R6: a set beats a concurrent clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_set && status_clr) |=> brk_flag);
endmodule

// File: rtl/uart_break_detector.sv
// Top level: break detection, end-of-break tracking, sticky status and interrupt.
// Assumes a separate receiver core supplies frame results and line samples.
module uart_break_detector #(
    parameter int DATA_W       = 8,
    parameter int HIGH_SAMPLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_parity,
    input  logic              frame_stop,
    input  logic              sync_mode,
    input  logic              line_in,
    input  logic              sample_tick,
    input  logic              brk_mask,
    input  logic              status_clr,
    output logic              brk_flag,
    output logic              frame_err,
    output logic              irq
);
    logic is_break, is_ferr, end_evt, in_break;

    brk_frame_classify #(.DATA_W(DATA_W)) u_classify (
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_parity(frame_parity),
        .frame_stop  (frame_stop),
        .is_break    (is_break),
        .is_ferr     (is_ferr)
    );

    brk_end_detect #(.HIGH_SAMPLES(HIGH_SAMPLES)) u_end (
        .clk        (clk),
        .rst_n      (rst_n),
        .break_seen (is_break),
        .sync_mode  (sync_mode),
        .line_in    (line_in),
        .sample_tick(sample_tick),
        .end_evt    (end_evt),
        .in_break   (in_break)
    );

    brk_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_set   (is_break | end_evt),
        .ferr_set  (is_ferr),
        .status_clr(status_clr),
        .brk_flag  (brk_flag),
        .frame_err (frame_err)
    );

    // Interrupt follows the masked break flag
    always_comb irq = brk_flag & brk_mask;

    // R1: a break frame raises the break flag
    assert_brk_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_break |=> brk_flag);
    // R1: a break frame never raises the framing-error flag
    assert_brk_no_ferr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_break && !frame_err) |=> !frame_err);
    // R2: a framing error leaves the break flag alone
    assert_ferr_keeps_brk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ferr && !end_evt && !brk_flag) |=> !brk_flag);
endmodule

// File: tb/uart_break_detector_test.sv
module uart_break_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [7:0] frame_data = '0;
    logic       frame_parity = 1'b0;
    logic       frame_stop = 1'b1;
    logic       sync_mode = 1'b0;
    logic       line_in = 1'b0;
    logic       sample_tick = 1'b0;
    logic       brk_mask = 1'b0;
    logic       status_clr = 1'b0;
    logic       brk_flag, frame_err, irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    uart_break_detector #(.DATA_W(8), .HIGH_SAMPLES(2)) uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_parity(frame_parity), .frame_stop(frame_stop), .sync_mode(sync_mode),
        .line_in(line_in), .sample_tick(sample_tick), .brk_mask(brk_mask),
        .status_clr(status_clr), .brk_flag(brk_flag), .frame_err(frame_err), .irq(irq)
    );

    // {data[7:0], parity, stop, expected brk_flag, expected frame_err}
    localparam logic [11:0] VEC [6] = '{
        {8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic p, input logic s);
        frame_data = d; frame_parity = p; frame_stop = s; frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; frame_stop = 1'b1;
    endtask

    task automatic clear();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    task automatic tick(input logic l);
        line_in = l; sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(brk_flag, 1'b0, "reset brk_flag");
        check(frame_err, 1'b0, "reset frame_err");
        check(irq, 1'b0, "reset irq");

        // R1 R2 R3: frame classification table
        for (int i = 0; i < 6; i++) begin
            clear();
            send_frame(VEC[i][11:4], VEC[i][3], VEC[i][2]);
            check(brk_flag, VEC[i][1], "R1/R2/R3 brk_flag");
            check(frame_err, VEC[i][0], "R1/R2/R3 frame_err");
        end

        // R7: end the pending break with two high samples
        clear();
        tick(1'b1);
        check(brk_flag, 1'b0, "R7 one high sample");
        tick(1'b1);
        check(brk_flag, 1'b1, "R7 two high samples");

        // R9: idle after end of break, highs ignored
        clear();
        tick(1'b1); tick(1'b1); tick(1'b1);
        check(brk_flag, 1'b0, "R9 idle highs ignored");

        // R4: interrupt gating
        send_frame(8'h00, 1'b0, 1'b0);
        check(irq, 1'b0, "R4 masked irq");
        brk_mask = 1'b1;
        #1 check(irq, 1'b1, "R4 unmasked irq");

        // R5: clear
        clear();
        check(brk_flag, 1'b0, "R5 clear brk_flag");
        check(irq, 1'b0, "R4 irq follows clear");

        // R7: low sample restarts count
        tick(1'b1); tick(1'b0); tick(1'b1);
        check(brk_flag, 1'b0, "R7 interrupted run");
        // R10: line changes without tick ignored
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        tick(1'b1);
        check(brk_flag, 1'b1, "R10 non-tick low ignored");

        // R9: after end, nothing more
        clear();
        tick(1'b1); tick(1'b1);
        check(brk_flag, 1'b0, "R9 after end idle");

        // R6: break frame with clear same cycle
        status_clr = 1'b1;
        send_frame(8'h00, 1'b0, 1'b0);
        status_clr = 1'b0;
        check(brk_flag, 1'b1, "R6 set wins over clear");

        // R6: end event with clear same cycle
        clear();
        tick(1'b1);
        status_clr = 1'b1;
        tick(1'b1);
        status_clr = 1'b0;
        check(brk_flag, 1'b1, "R6 end event wins over clear");

        // R2 + R5: framing error clear
        send_frame(8'h10, 1'b0, 1'b0);
        clear();
        check(frame_err, 1'b0, "R5 clear frame_err");

        // R8: synchronous end of break
        sync_mode = 1'b1;
        send_frame(8'h00, 1'b0, 1'b0);
        clear();
        tick(1'b0);
        check(brk_flag, 1'b0, "R8 low sample");
        tick(1'b1);
        check(brk_flag, 1'b1, "R8 first high sample");
        clear();
        tick(1'b1);
        check(brk_flag, 1'b0, "R9 sync idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule